// File: doc/BRIEF.md
# Multi-lane BIST error checker

This block checks the receive side of a parallel link while the link tests itself. On every clock it compares one word of received bits, one bit per lane, against the word the receiver should have seen. The pattern generator and the delimiter detector sit outside the block. The checker only needs three things: a one-cycle start pulse, a strobe that marks the start delimiter, and the two lane vectors.

Once started, the block reports status code 01 until the delimiter strobe arrives. Comparison begins on the word after that strobe. Mismatches are counted per lane, and all of the lanes that fail in one word are added together in the same cycle. The count sits in a 10-bit accumulator that saturates instead of wrapping. The first failing word sets the status to 10 and records the highest-numbered failing lane. Two control inputs set how a run ends:
- **Stop on error:** the run halts on the first failing word.
- **Loop forever:** the run never ends.
- **Neither set:** the run ends after a programmed number of words.

Top module: `bist_lane_checker`

## Requirements
- R1: While reset is asserted, the error count is 0, the error lane is 0, status is 00 and done is 0.
- R2: A start pulse clears the count, lane and done flag and sets status to 01 on the next edge. Words received while status is 01 are never compared and leave the count at 0.
- R3: A delimiter strobe while status is 01 changes the status to 00. The word presented with the strobe is not compared. Comparison starts with the following word.
- R4: Each compared word adds the number of its mismatching lanes (rx XOR expected, counted as ones) to the error count in that cycle.
- R5: The error count saturates at 1023 and never wraps to a smaller value.
- R6: The first word with any mismatch sets status to 10 and loads the error lane with the highest-numbered mismatching lane of that word. Later errors change neither the lane nor the status. Status 11 never appears.
- R7: With stop-on-error set, the first failing word is counted, done rises, and later words are not counted.
- R8: With stop-on-error clear, failing words keep being counted until the run ends.
- R9: With loop-forever clear, done rises after the programmed number of compared words, and the count stops changing. A programmed length of 0 acts as 1.
- R10: With loop-forever set, done never rises unless stop-on-error ends the run, and counting continues without limit.
- R11: A start pulse during a run or after done restarts the test exactly as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a test |
| delim_i | input | 1 | Strobe: start delimiter received |
| rx_bits_i | input | 16 | Received bit per lane |
| exp_bits_i | input | 16 | Expected bit per lane |
| stop_on_err_i | input | 1 | Halt the run at the first failing word |
| loop_i | input | 1 | Run without end |
| test_len_i | input | 16 | Compared words per run when not looping |
| err_count_o | output | 10 | Saturating total of lane errors |
| err_lane_o | output | 4 | Highest failing lane of the first failing word |
| status_o | output | 2 | 01 waiting for delimiter, 00 clean, 10 error seen |
| done_o | output | 1 | Run finished |

## Verification
The bench drives mismatched data before the delimiter and on the delimiter word itself. A design that compares too early shows a nonzero count there. Words whose mismatches are spread across several lanes show whether a design adds one per word instead of the popcount. The same words show whether the design logs the lowest failing lane, or lets a later error overwrite the logged lane. Further runs cover:
- stopping on error, where extra counts appear after the halt;
- a length of four words and a length of zero, where an off-by-one done shows up;
- looping, where done must never rise;
- a long all-lanes-failing stream, where the count must hold at 1023 rather than wrap;
- a restart in the middle of a run, where stale state shows up.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;

   typedef enum logic [1:0] {
      ST_CLEAN  = 2'b00,
      ST_NO_DLM = 2'b01,
      ST_TX_ERR = 2'b10,
      ST_RSVD   = 2'b11
   } bist_stat_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_RUN  = 2'd2
   } bist_phase_e;

endpackage

// File: rtl/bist_lane_cmp.sv
module bist_lane_cmp #(
   parameter int LANES = 16,
   parameter int PC_W  = 5,
   parameter int IDX_W = 4
) (
   input  logic [LANES-1:0] rx_i,
   input  logic [LANES-1:0] exp_i,
   output logic [PC_W-1:0]  nerr_o,
   output logic [IDX_W-1:0] top_lane_o,
   output logic             any_err_o
);

   logic [LANES-1:0] mism;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_xor
         assign mism[g] = rx_i[g] ^ exp_i[g];
      end
   endgenerate

   // ascending scan: the last hit is the highest lane
   always_comb begin
      nerr_o     = '0;
      top_lane_o = '0;
      for (int i = 0; i < LANES; i++) begin
         if (mism[i]) begin
            nerr_o     = nerr_o + PC_W'(1);
            top_lane_o = IDX_W'(i);
         end
      end
   end

   assign any_err_o = |mism;

endmodule

// File: rtl/bist_err_accum.sv
module bist_err_accum #(
   parameter int CNT_W    = 10,
   parameter int PC_W     = 5,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic [PC_W-1:0]  inc_i,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   generate
      if (SATURATE) begin : g_sat
         localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
         logic [CNT_W:0] sum;
         assign sum     = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);
         assign cnt_nxt = sum[CNT_W] ? MAXV : sum[CNT_W-1:0];

         assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_i |=> cnt_q >= $past(cnt_q));
      end else begin : g_wrap
         assign cnt_nxt = cnt_q + CNT_W'(inc_i);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (en_i)   cnt_q <= cnt_nxt;
   end

   assign cnt_o = cnt_q;

   assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !en_i) |=> $stable(cnt_q));

endmodule

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
   import bist_chk_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             delim_i,
   input  logic             any_err_i,
   input  logic [IDX_W-1:0] top_lane_i,
   input  logic             stop_on_err_i,
   input  logic             loop_i,
   input  logic [LEN_W-1:0] test_len_i,
   output logic             run_o,
   output bist_stat_e       status_o,
   output logic [IDX_W-1:0] lane_o,
   output logic             done_o
);

   bist_phase_e      phase_q;
   bist_stat_e       status_q;
   logic [IDX_W-1:0] lane_q;
   logic             done_q;
   logic [LEN_W-1:0] words_q;
   logic [LEN_W-1:0] last_word;
   logic             halt_err;
   logic             halt_len;

   assign last_word = (test_len_i == '0) ? '0 : test_len_i - LEN_W'(1);
   assign halt_err  = any_err_i && stop_on_err_i;
   assign halt_len  = !loop_i && (words_q >= last_word);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         status_q <= ST_CLEAN;
         lane_q   <= '0;
         done_q   <= 1'b0;
         words_q  <= '0;
      end else if (start_i) begin
         phase_q  <= PH_WAIT;
         status_q <= ST_NO_DLM;
         lane_q   <= '0;
         done_q   <= 1'b0;
         words_q  <= '0;
      end else begin
         case (phase_q)
            PH_WAIT: begin
               if (delim_i) begin
                  phase_q  <= PH_RUN;
                  status_q <= ST_CLEAN;
               end
            end
            PH_RUN: begin
               if (any_err_i && status_q == ST_CLEAN) begin
                  status_q <= ST_TX_ERR;
                  lane_q   <= top_lane_i;
               end
               if (halt_err || halt_len) begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
               end else if (!loop_i) begin
                  words_q <= words_q + LEN_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

   assign run_o    = (phase_q == PH_RUN) && !start_i;
   assign status_o = status_q;
   assign lane_o   = lane_q;
   assign done_o   = done_q;

   assert_no_rsvd_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      status_q != ST_RSVD);

   assert_lane_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q == ST_TX_ERR && !start_i) |=> $stable(lane_q));

   assert_wait_dlm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_WAIT && !delim_i && !start_i) |=> status_q == ST_NO_DLM);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> phase_q == PH_IDLE);

   assert_loop_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_i && phase_q == PH_RUN && !halt_err && !start_i) |=> !done_q);

   assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (status_q == ST_NO_DLM && !done_q && lane_q == '0));

endmodule

// File: rtl/bist_lane_checker.sv
module bist_lane_checker
   import bist_chk_pkg::*;
#(
   parameter int LANES    = 16,
   parameter int CNT_W    = 10,
   parameter int LEN_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  delim_i,
   input  logic [LANES-1:0]      rx_bits_i,
   input  logic [LANES-1:0]      exp_bits_i,
   input  logic                  stop_on_err_i,
   input  logic                  loop_i,
   input  logic [LEN_W-1:0]      test_len_i,
   output logic [CNT_W-1:0]      err_count_o,
   output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] err_lane_o,
   output logic [1:0]            status_o,
   output logic                  done_o
);

   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int PC_W  = $clog2(LANES + 1);

   initial begin
      assert (LANES >= 1 && LANES <= 16)
         else $error("LANES must lie in 1..16");
      assert (CNT_W >= PC_W)
         else $error("CNT_W too narrow for one word of errors");
      assert (LEN_W >= 1)
         else $error("LEN_W must be positive");
   end

   logic [PC_W-1:0]  nerr;
   logic [IDX_W-1:0] top_lane;
   logic             any_err;
   logic             run;
   bist_stat_e       status;

   bist_lane_cmp #(
      .LANES (LANES),
      .PC_W  (PC_W),
      .IDX_W (IDX_W)
   ) u_cmp (
      .rx_i       (rx_bits_i),
      .exp_i      (exp_bits_i),
      .nerr_o     (nerr),
      .top_lane_o (top_lane),
      .any_err_o  (any_err)
   );

   bist_seq_ctrl #(
      .IDX_W (IDX_W),
      .LEN_W (LEN_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .delim_i       (delim_i),
      .any_err_i     (any_err),
      .top_lane_i    (top_lane),
      .stop_on_err_i (stop_on_err_i),
      .loop_i        (loop_i),
      .test_len_i    (test_len_i),
      .run_o         (run),
      .status_o      (status),
      .lane_o        (err_lane_o),
      .done_o        (done_o)
   );

   bist_err_accum #(
      .CNT_W    (CNT_W),
      .PC_W     (PC_W),
      .SATURATE (SATURATE)
   ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (start_i),
      .en_i  (run),
      .inc_i (nerr),
      .cnt_o (err_count_o)
   );

   assign status_o = status;

   assert_no_count_before_dlm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (status == ST_NO_DLM) |-> err_count_o == '0);

   assert_stop_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && any_err && stop_on_err_i) |=> (done_o && !run));

   assert_word_popcount_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !any_err) |=> $stable(err_count_o));

endmodule

// File: tb/bist_lane_checker_tb_top.sv
module bist_lane_checker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i, delim_i, stop_on_err_i, loop_i;
   logic [15:0] rx_bits_i, exp_bits_i, test_len_i;
   logic [9:0]  err_count_o;
   logic [3:0]  err_lane_o;
   logic [1:0]  status_o;
   logic        done_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   bist_lane_checker dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .delim_i       (delim_i),
      .rx_bits_i     (rx_bits_i),
      .exp_bits_i    (exp_bits_i),
      .stop_on_err_i (stop_on_err_i),
      .loop_i        (loop_i),
      .test_len_i    (test_len_i),
      .err_count_o   (err_count_o),
      .err_lane_o    (err_lane_o),
      .status_o      (status_o),
      .done_o        (done_o)
   );

   // {rx, expected, count after word, lane, status}
   localparam logic [51:0] VEC [8] = '{
      {16'hA5A5, 16'hA5A5, 12'd0,  4'd0, 4'd0},
      {16'h0006, 16'h0000, 12'd2,  4'd2, 4'd2},
      {16'hFFFF, 16'h0000, 12'd18, 4'd2, 4'd2},
      {16'h8000, 16'h0000, 12'd19, 4'd2, 4'd2},
      {16'h1234, 16'h1234, 12'd19, 4'd2, 4'd2},
      {16'h00FF, 16'h0F0F, 12'd27, 4'd2, 4'd2},
      {16'hFFFF, 16'h7FFE, 12'd29, 4'd2, 4'd2},
      {16'h0000, 16'hFFFF, 12'd45, 4'd2, 4'd2}
   };

   task automatic chk(input string req, input int act, input int expv);
      n_tests++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic step(input logic [15:0] rx, input logic [15:0] ex,
                       input logic dl, input logic st);
      rx_bits_i  = rx;
      exp_bits_i = ex;
      delim_i    = dl;
      start_i    = st;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start_i = 0; delim_i = 0; stop_on_err_i = 0; loop_i = 1;
      rx_bits_i = '0; exp_bits_i = '0; test_len_i = '0;
      repeat (3) @(negedge clk);
      chk("R1 count", int'(err_count_o), 0);
      chk("R1 lane", int'(err_lane_o), 0);
      chk("R1 status", int'(status_o), 0);
      chk("R1 done", int'(done_o), 0);
      rst_n = 1'b1;

      // R2: nothing compared before the delimiter
      step(16'h0, 16'h0, 0, 1);
      chk("R2 status after start", int'(status_o), 1);
      for (int i = 0; i < 3; i++) step(16'hFFFF, 16'h0, 0, 0);
      chk("R2 count before delimiter", int'(err_count_o), 0);
      chk("R2 status held", int'(status_o), 1);
      // R3: delimiter word itself not compared
      step(16'hFFFF, 16'h0, 1, 0);
      chk("R3 status after delimiter", int'(status_o), 0);
      chk("R3 delimiter word ignored", int'(err_count_o), 0);

      // R4 R6 R8: table walk
      for (int i = 0; i < 8; i++) begin
         step(VEC[i][51:36], VEC[i][35:20], 0, 0);
         chk("R4 R8 count", int'(err_count_o), int'(VEC[i][19:8]));
         chk("R6 lane", int'(err_lane_o), int'(VEC[i][7:4]));
         chk("R6 status", int'(status_o), int'(VEC[i][3:0]));
      end
      chk("R10 no done while looping", int'(done_o), 0);

      // R7: stop on error
      stop_on_err_i = 1;
      step(16'h0, 16'h0, 0, 1);
      chk("R11 restart count", int'(err_count_o), 0);
      chk("R11 restart lane", int'(err_lane_o), 0);
      step(16'h0, 16'h0, 1, 0);
      step(16'h1234, 16'h1234, 0, 0);
      chk("R7 clean word", int'(done_o), 0);
      step(16'h0030, 16'h0, 0, 0);
      chk("R7 first error counted", int'(err_count_o), 2);
      chk("R7 lane", int'(err_lane_o), 5);
      chk("R7 done", int'(done_o), 1);
      step(16'hFFFF, 16'h0, 0, 0);
      chk("R7 no count after halt", int'(err_count_o), 2);
      chk("R7 status", int'(status_o), 2);

      // R9: four-word run
      stop_on_err_i = 0; loop_i = 0; test_len_i = 16'd4;
      step(16'h0, 16'h0, 0, 1);
      chk("R11 done cleared", int'(done_o), 0);
      step(16'h0, 16'h0, 1, 0);
      for (int i = 0; i < 3; i++) step(16'h0001, 16'h0, 0, 0);
      chk("R9 count before end", int'(err_count_o), 3);
      chk("R9 not done early", int'(done_o), 0);
      step(16'h0001, 16'h0, 0, 0);
      chk("R9 done at length", int'(done_o), 1);
      chk("R9 count at end", int'(err_count_o), 4);
      step(16'h0001, 16'h0, 0, 0);
      chk("R9 frozen after done", int'(err_count_o), 4);

      // R9: zero length acts as one
      test_len_i = 16'd0;
      step(16'h0, 16'h0, 0, 1);
      step(16'h0, 16'h0, 1, 0);
      step(16'h0, 16'h0, 0, 0);
      chk("R9 zero length done", int'(done_o), 1);
      step(16'hFFFF, 16'h0, 0, 0);
      chk("R9 zero length frozen", int'(err_count_o), 0);

      // R10: looping ignores length
      loop_i = 1; test_len_i = 16'd4;
      step(16'h0, 16'h0, 0, 1);
      step(16'h0, 16'h0, 1, 0);
      for (int i = 0; i < 6; i++) step(16'h0002, 16'h0, 0, 0);
      chk("R10 count", int'(err_count_o), 6);
      chk("R10 no done", int'(done_o), 0);
      chk("R6 lane one", int'(err_lane_o), 1);

      // R11: restart mid-run
      step(16'hFFFF, 16'h0, 0, 1);
      chk("R11 mid-run count", int'(err_count_o), 0);
      chk("R11 mid-run status", int'(status_o), 1);
      chk("R11 mid-run lane", int'(err_lane_o), 0);

      // R5: saturation
      step(16'h0, 16'h0, 1, 0);
      for (int i = 0; i < 63; i++) step(16'hFFFF, 16'h0, 0, 0);
      chk("R5 before limit", int'(err_count_o), 1008);
      step(16'hFFFF, 16'h0, 0, 0);
      chk("R5 saturated", int'(err_count_o), 1023);
      step(16'hFFFF, 16'h0, 0, 0);
      chk("R5 stays saturated", int'(err_count_o), 1023);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule